// File: doc/BRIEF.md
# Up/Down Counter with Parallel Load and Terminal Flag

This block is a synchronous binary counter whose width is a parameter (four bits by default). On every rising clock edge the count register takes one of four values: zero, a parallel word, the current count plus one, or the current count minus one. If none of these is selected, it keeps its present value. A single direction input sets whether the count rises or falls. The same input also decides which value counts as terminal: all ones when counting up, all zeros when counting down.

The terminal flag is decoded combinationally from the present count and direction. It does not wait for a clock edge and is not qualified by the count enable. A controller can therefore see it before deciding whether to reload or stop. The plus-one and minus-one paths are separate units, and a parameter chooses whether they are built as explicit carry and borrow chains or as behavioural arithmetic.

Top module: `updn_tc_counter`

## Requirements
- R1: When `clr` is 1 at a rising edge, the count becomes 0 after that edge, whatever `ld`, `cnt` and `dir` are.
- R2: When `clr` is 0 and `ld` is 1 at a rising edge, the count becomes `ld_val` after that edge, whatever `cnt` and `dir` are.
- R3: When `clr` and `ld` are 0, `cnt` is 1 and `dir` is 1 (up) at a rising edge, the count becomes its previous value plus one modulo 2^WIDTH, so the all-ones value wraps to 0.
- R4: When `clr` and `ld` are 0, `cnt` is 1 and `dir` is 0 (down) at a rising edge, the count becomes its previous value minus one modulo 2^WIDTH, so 0 wraps to all ones.
- R5: When `clr`, `ld` and `cnt` are all 0 at a rising edge, the count keeps its value, whatever `dir` is.
- R6: While `dir` is 1, `tc` is 1 exactly when every count bit is 1.
- R7: While `dir` is 0, `tc` is 1 exactly when every count bit is 0.
- R8: `tc` follows a change of `dir` within the same cycle, without a clock edge, and does not depend on `cnt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear to zero; highest priority |
| ld | input | 1 | Synchronous parallel load; second priority |
| ld_val | input | WIDTH | Word loaded when `ld` wins |
| cnt | input | 1 | Count enable; lowest priority |
| dir | input | 1 | 1 counts up, 0 counts down; also selects the terminal value |
| count | output | WIDTH | Present count |
| tc | output | 1 | Terminal flag for the selected direction |

## Verification
The hardest cases to reach are the two wrap points with the correct direction applied, and the moment the terminal flag changes meaning while the count is frozen. The stimulus starts with a clear, runs the count up through all 2^WIDTH states so that the all-ones value and its wrap to zero both appear, and then runs down through all states so that zero and its wrap to all ones appear. It then parks the counter at zero and at all ones with `cnt` low and toggles `dir` in the middle of a cycle. Because the count is fixed in those cycles, any change in `tc` can only come from the direction input.

// File: rtl/updn_tc_pkg.sv
package updn_tc_pkg;
   typedef enum logic [1:0] {
      SRC_HOLD = 2'd0,
      SRC_ZERO = 2'd1,
      SRC_LOAD = 2'd2,
      SRC_STEP = 2'd3
   } nxt_src_e;

   localparam int STEP_CHAIN = 0;
   localparam int STEP_ARITH = 1;
endpackage

// File: rtl/updn_tc_step.sv
module updn_tc_step #(
   parameter int WIDTH      = 4,
   parameter int STEP_STYLE = 0
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] plus_one,
   output logic [WIDTH-1:0] minus_one
);
   import updn_tc_pkg::*;

   initial begin
      if (STEP_STYLE != STEP_CHAIN && STEP_STYLE != STEP_ARITH)
         $error("updn_tc_step: STEP_STYLE out of range");
   end

   generate
      if (STEP_STYLE == STEP_CHAIN) begin : g_chain
         logic [WIDTH:0] carry;
         logic [WIDTH:0] borrow;
         assign carry[0]  = 1'b1;
         assign borrow[0] = 1'b1;
         for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            assign plus_one[b]  = cur[b] ^ carry[b];
            assign carry[b+1]   = cur[b] & carry[b];
            assign minus_one[b] = cur[b] ^ borrow[b];
            assign borrow[b+1]  = ~cur[b] & borrow[b];
         end
      end else begin : g_arith
         localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
         assign plus_one  = cur + ONE;
         assign minus_one = cur + {WIDTH{1'b1}};
      end
   endgenerate
endmodule

// File: rtl/updn_tc_term.sv
module updn_tc_term #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             up,
   output logic             term
);
   logic all_hi;
   logic all_lo;

   assign all_hi = &cur;
   assign all_lo = ~(|cur);
   assign term   = up ? all_hi : all_lo;
endmodule

// File: rtl/updn_tc_sel.sv
module updn_tc_sel #(
   parameter int WIDTH = 4
) (
   input  logic             clr,
   input  logic             ld,
   input  logic             cnt,
   input  logic             up,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] ld_val,
   input  logic [WIDTH-1:0] plus_one,
   input  logic [WIDTH-1:0] minus_one,
   output logic [WIDTH-1:0] nxt
);
   import updn_tc_pkg::*;

   nxt_src_e src;

   always_comb begin
      if (clr)      src = SRC_ZERO;
      else if (ld)  src = SRC_LOAD;
      else if (cnt) src = SRC_STEP;
      else          src = SRC_HOLD;
   end

   always_comb begin
      unique case (src)
         SRC_ZERO: nxt = '0;
         SRC_LOAD: nxt = ld_val;
         SRC_STEP: nxt = up ? plus_one : minus_one;
         default:  nxt = cur;
      endcase
   end
endmodule

// File: rtl/updn_tc_counter.sv
module updn_tc_counter #(
   parameter int WIDTH      = 4,
   parameter int STEP_STYLE = 0
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             ld,
   input  logic [WIDTH-1:0] ld_val,
   input  logic             cnt,
   input  logic             dir,
   output logic [WIDTH-1:0] count,
   output logic             tc
);
   initial begin
      if (WIDTH < 2) $error("updn_tc_counter: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_d;
   logic [WIDTH-1:0] inc_v;
   logic [WIDTH-1:0] dec_v;

   updn_tc_step #(.WIDTH(WIDTH), .STEP_STYLE(STEP_STYLE)) u_step (
      .cur       (cnt_q),
      .plus_one  (inc_v),
      .minus_one (dec_v)
   );

   updn_tc_sel #(.WIDTH(WIDTH)) u_sel (
      .clr       (clr),
      .ld        (ld),
      .cnt       (cnt),
      .up        (dir),
      .cur       (cnt_q),
      .ld_val    (ld_val),
      .plus_one  (inc_v),
      .minus_one (dec_v),
      .nxt       (cnt_d)
   );

   updn_tc_term #(.WIDTH(WIDTH)) u_term (
      .cur  (cnt_q),
      .up   (dir),
      .term (tc)
   );

   always_ff @(posedge clk) begin
      cnt_q <= cnt_d;
   end

   assign count = cnt_q;
endmodule

// File: rtl/updn_tc_chk.sv
module updn_tc_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             clr,
   input logic             ld,
   input logic [WIDTH-1:0] ld_val,
   input logic             cnt,
   input logic             dir,
   input logic [WIDTH-1:0] count,
   input logic             tc
);
   localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
   localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

   logic armed = 1'b0;
   always_ff @(posedge clk) begin
      if (clr) armed <= 1'b1;
   end

   assert_clear_R1: assert property (@(posedge clk) disable iff (!armed)
      $past(clr) |-> count == '0);

   assert_load_R2: assert property (@(posedge clk) disable iff (!armed)
      $past(!clr && ld) |-> count == $past(ld_val));

   assert_up_step_R3: assert property (@(posedge clk) disable iff (!armed)
      $past(!clr && !ld && cnt && dir) |-> count == $past(count) + ONE);

   assert_down_step_R4: assert property (@(posedge clk) disable iff (!armed)
      $past(!clr && !ld && cnt && !dir) |-> count == $past(count) - ONE);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!armed)
      $past(!clr && !ld && !cnt) |-> $stable(count));

   assert_up_term_R6: assert property (@(posedge clk) disable iff (!armed)
      dir |-> tc == (count == ONES));

   assert_down_term_R7: assert property (@(posedge clk) disable iff (!armed)
      !dir |-> tc == (count == '0));

   assert_dir_flip_R8: assert property (@(posedge clk) disable iff (!armed)
      ($stable(count) && (dir != $past(dir)) && (count == '0 || count == ONES))
      |-> tc != $past(tc));
endmodule

bind updn_tc_counter updn_tc_chk #(.WIDTH(WIDTH)) u_updn_tc_chk (
   .clk    (clk),
   .clr    (clr),
   .ld     (ld),
   .ld_val (ld_val),
   .cnt    (cnt),
   .dir    (dir),
   .count  (count),
   .tc     (tc)
);

// File: tb/test_updn_tc_counter.sv
`timescale 1ns/1ps
module test_updn_tc_counter;
   localparam int W    = 4;
   localparam int MAXV = (1 << W) - 1;

   typedef struct {
      int    exp_cnt;
      bit    exp_tc;
      string tag;
   } item_t;

   logic         clk = 1'b0;
   logic         clr = 1'b0;
   logic         ld  = 1'b0;
   logic [W-1:0] ld_val = '0;
   logic         cnt = 1'b0;
   logic         dir = 1'b1;
   logic [W-1:0] count;
   logic         tc;

   int    checks   = 0;
   int    failures = 0;
   int    model    = 0;
   item_t sb[$];
   bit    finished = 1'b0;

   always #5 clk = ~clk;

   updn_tc_counter #(.WIDTH(W)) i_updn_tc_counter (
      .clk(clk), .clr(clr), .ld(ld), .ld_val(ld_val),
      .cnt(cnt), .dir(dir), .count(count), .tc(tc)
   );

   function automatic bit term_of(int v, bit up);
      return up ? (v == MAXV) : (v == 0);
   endfunction

   // driver: one clock cycle of stimulus, expected result pushed to scoreboard
   task automatic apply(bit c, bit l, int v, bit e, bit d);
      item_t it;
      @(negedge clk);
      clr = c; ld = l; ld_val = v[W-1:0]; cnt = e; dir = d;
      if (c) begin
         model = 0; it.tag = "R1";
      end else if (l) begin
         model = v & MAXV; it.tag = "R2";
      end else if (e && d) begin
         model = (model + 1) & MAXV; it.tag = "R3";
      end else if (e) begin
         model = (model - 1) & MAXV; it.tag = "R4";
      end else begin
         it.tag = "R5";
      end
      it.exp_cnt = model;
      it.exp_tc  = term_of(model, d);
      sb.push_back(it);
   endtask

   // direct mid-cycle check of tc after a dir change with no clock edge (R8)
   task automatic flip_dir_check(bit d);
      @(negedge clk);
      #1;
      dir = d; cnt = 1'b0; clr = 1'b0; ld = 1'b0;
      #1;
      checks++;
      if (tc !== term_of(model, d)) begin
         failures++;
         $display("FAIL R8 dir=%0b count=%0d tc actual=%0b expected=%0b",
                  d, model, tc, term_of(model, d));
      end
   endtask

   // monitor: compare after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (count !== it.exp_cnt[W-1:0]) begin
               failures++;
               $display("FAIL %s count actual=%0d expected=%0d", it.tag, count, it.exp_cnt);
            end
            checks++;
            if (tc !== it.exp_tc) begin
               failures++;
               $display("FAIL %s tc (dir=%0b R6/R7) actual=%0b expected=%0b",
                        it.tag, dir, tc, it.exp_tc);
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: clear wins over load and count
      apply(1, 1, 9, 1, 1);
      apply(1, 0, 0, 0, 0);
      // R2: load wins over count, both directions
      apply(0, 1, 5, 1, 1);
      apply(0, 1, 10, 1, 0);
      // R5: hold with dir toggling
      apply(0, 0, 3, 0, 1);
      apply(0, 0, 3, 0, 0);
      // R3/R6: full up sweep from 0, through all-ones and the wrap
      apply(1, 0, 0, 0, 1);
      for (int i = 0; i < MAXV + 2; i++) apply(0, 0, 0, 1, 1);
      // R4/R7: full down sweep, through zero and the wrap to all ones
      for (int i = 0; i < MAXV + 3; i++) apply(0, 0, 0, 1, 0);
      // mid-count direction changes
      apply(0, 1, 7, 0, 1);
      apply(0, 0, 0, 1, 1);
      apply(0, 0, 0, 1, 0);
      apply(0, 0, 0, 1, 0);
      apply(0, 0, 0, 1, 1);
      // R8: park at zero and all ones, flip dir mid-cycle with cnt low
      apply(1, 0, 0, 0, 1);
      flip_dir_check(1'b0);
      flip_dir_check(1'b1);
      apply(0, 1, MAXV, 0, 0);
      flip_dir_check(1'b1);
      flip_dir_check(1'b0);
      // R5: all-ones held under cnt low with dir set up
      apply(0, 0, 0, 0, 1);
      apply(0, 0, 0, 0, 0);
      @(negedge clk);
      clr = 0; ld = 0; cnt = 0;
      while (sb.size() > 0) @(negedge clk);
      @(negedge clk);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule